// File: doc/BRIEF.md
# Interrupt Vector Request Tracker

This block keeps the interrupt bookkeeping of a processor-local interrupt controller. It holds two 256-entry vector sets. The request set marks vectors that have been delivered but not yet taken by the core. The in-service set marks vectors whose handlers are running. For each set it keeps a registered copy of the highest-numbered vector present. The core uses the top request vector to decide what to take next, and an end-of-interrupt retires the top in-service vector.

Four delivery kinds never enter the request set: system-management, non-maskable, external and init. Each has its own pending flag and a latched copy of the message payload that raised it. The core clears a flag with a per-kind take strobe. A summary output reports that an unmaskable event is waiting. It covers system-management, non-maskable and init, and it leaves out external on purpose.

A read port returns any 32-bit word of either set. Vector v is held in word v[7:5] at bit v[4:0]. A format word resets to all ones, which selects flat logical addressing.

Top module: `irq_vec_tracker`

## Requirements
- R1: After a synchronous active-low reset, both sets, all four pending flags, the summary flag and both top-vector outputs read zero, and `fmt_word` reads 0xFFFFFFFF.
- R2: A message with `msg_kind` 0 (fixed) sets request bit v, which the read port shows at word v[7:5], bit v[4:0]. `rd_sel` 0 selects the request set and 1 selects the in-service set.
- R3: `top_req` and `top_isr` report the highest-numbered vector in their set. The value is word index times 32 plus the position of the highest set bit in the highest nonzero word.
- R4: A set with no bit set reports a top vector of 0.
- R5: An acknowledge for vector v clears request bit v and sets in-service bit v at the same clock edge.
- R6: If a fixed message and an acknowledge name the same vector in the same cycle, the request bit stays set and the in-service bit is still set.
- R7: An end-of-interrupt clears the in-service bit at the current `top_isr`. When the in-service set is empty it changes nothing.
- R8: `msg_kind` 1, 2, 3 and 4 (system-management, non-maskable, external, init) set `pend[0]`, `pend[1]`, `pend[2]` and `pend[3]` respectively. Each also latches `msg_data` into slot k of `spec_msgs` (bits 32k+31:32k), and no request bit changes.
- R9: `take[k]` clears `pend[k]`. A new message of the same kind in the same cycle wins, so the flag stays set.
- R10: `unmask_pend` is high exactly when `pend[0]`, `pend[1]` or `pend[3]` is set. `pend[2]` alone leaves it low.
- R11: `msg_kind` codes 5, 6 and 7 change neither set nor any flag.
- R12: The top-vector outputs are registered. They show a change to their set one clock after the set itself changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Accept an incoming message this cycle |
| msg_kind | input | 3 | Delivery kind: 0 fixed, 1 system-management, 2 non-maskable, 3 external, 4 init |
| msg_vector | input | 8 | Vector number of a fixed message |
| msg_data | input | 32 | Message payload latched for the special kinds |
| ack_valid | input | 1 | Core takes a vector into service |
| ack_vector | input | 8 | Vector being taken |
| eoi_valid | input | 1 | End-of-interrupt for the top in-service vector |
| take | input | 4 | Per-kind clear strobes for the special flags |
| rd_sel | input | 1 | Read set select: 0 request, 1 in-service |
| rd_word | input | 3 | Word index within the selected set |
| rd_data | output | 32 | Selected word |
| top_req | output | 8 | Highest pending request vector |
| top_isr | output | 8 | Highest in-service vector |
| pend | output | 4 | Special-kind pending flags |
| unmask_pend | output | 1 | Any of system-management, non-maskable or init pending |
| spec_msgs | output | 128 | Latched payloads, 32 bits per special kind |
| fmt_word | output | 32 | Destination format word |

## Verification
Some properties are checked by assertion on every cycle. A fixed message lands in the request set, and an acknowledge moves its bit into service. Each top output names the highest bit of the set as it stood one cycle before, and is zero for an empty set. Special kinds leave the request set alone, and take clears a flag. An end-of-interrupt on an empty in-service set does nothing, and an external-only pending state keeps the summary low. Other behaviour only the bench scenarios show: the word and bit placement seen through the read port, the exact latched payload per kind, the one-cycle lag of the top outputs, same-cycle collisions between a request and an acknowledge, and the order in which repeated end-of-interrupts drain the in-service set.

// File: rtl/irq_vec_pkg.sv
// Shared constants for the interrupt vector request tracker.
// Assumes 3-bit delivery kind codes and four special kinds.
package irq_vec_pkg;
    localparam logic [2:0] KIND_FIXED  = 3'd0;
    localparam logic [2:0] KIND_SMI    = 3'd1;
    localparam logic [2:0] KIND_NMI    = 3'd2;
    localparam logic [2:0] KIND_EXTINT = 3'd3;
    localparam logic [2:0] KIND_INIT   = 3'd4;

    localparam int NUM_SPECIAL = 4;
    localparam int SP_SMI  = 0;
    localparam int SP_NMI  = 1;
    localparam int SP_EXT  = 2;
    localparam int SP_INIT = 3;

    // Kind code that raises special slot k.
    function automatic logic [2:0] special_code(input int k);
        return 3'(k + 1);
    endfunction
endpackage

// File: rtl/irq_vec_set.sv
// One vector set stored as NUM_WORDS words of WORD_W bits.
// One set port and one clear port act per cycle. A set wins over a clear
// on the same vector. Assumes a power-of-two word width.
module irq_vec_set #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32,
    localparam int NUM_VEC   = 1 << VEC_W,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int BIT_W     = $clog2(WORD_W),
    localparam int WSEL_W    = VEC_W - BIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [VEC_W-1:0]   set_vec,
    input  logic               clr_en,
    input  logic [VEC_W-1:0]   clr_vec,
    output logic [NUM_VEC-1:0] bits
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic              set_hit;
        logic              clr_hit;
        logic [WORD_W-1:0] set_mask;
        logic [WORD_W-1:0] clr_mask;
        logic [WORD_W-1:0] word_q;

        // Decode whether this word is addressed by either port.
        assign set_hit = set_en && (set_vec[VEC_W-1:BIT_W] == WSEL_W'(w));
        assign clr_hit = clr_en && (clr_vec[VEC_W-1:BIT_W] == WSEL_W'(w));

        // Build the one-hot bit masks inside the word.
        assign set_mask = set_hit ? (WORD_W'(1) << set_vec[BIT_W-1:0]) : '0;
        assign clr_mask = clr_hit ? (WORD_W'(1) << clr_vec[BIT_W-1:0]) : '0;

        // Word storage: clear first, then set, so that a set wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= (word_q & ~clr_mask) | set_mask;
            end
        end

        assign bits[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/irq_msb_find.sv
// Highest-set-bit search over a word-organised vector set.
// The highest nonzero word gives the index, combined with its top bit.
// An empty set yields zero with any_set low. Purely combinational.
module irq_msb_find #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32,
    localparam int NUM_VEC   = 1 << VEC_W,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int BIT_W     = $clog2(WORD_W),
    localparam int WSEL_W    = VEC_W - BIT_W
) (
    input  logic [NUM_VEC-1:0] bits,
    output logic [VEC_W-1:0]   top,
    output logic               any_set
);
    logic [NUM_WORDS-1:0]            word_nz;
    logic [NUM_WORDS-1:0][BIT_W-1:0] word_msb;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [BIT_W-1:0] msb_local;

        // Position of the most significant set bit inside this word.
        always_comb begin
            msb_local = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) msb_local = BIT_W'(b);
            end
        end

        assign word_nz[w]  = |bits[w*WORD_W +: WORD_W];
        assign word_msb[w] = msb_local;
    end

    // Word-level priority: a higher nonzero word overrides a lower one.
    always_comb begin
        top = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_nz[w]) top = {WSEL_W'(w), word_msb[w]};
        end
    end

    assign any_set = |word_nz;
endmodule

// File: rtl/irq_special_flags.sv
// Pending flags and latched payloads for the delivery kinds that bypass
// the request set. A new message of a kind beats a take of the same kind.
module irq_special_flags #(
    parameter int MSG_W = 32,
    parameter int NSP   = irq_vec_pkg::NUM_SPECIAL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSP-1:0]     accept,
    input  logic [MSG_W-1:0]   msg_data,
    input  logic [NSP-1:0]     take,
    output logic [NSP-1:0]     pend,
    output logic [NSP*MSG_W-1:0] msgs
);
    for (genvar k = 0; k < NSP; k++) begin : g_kind
        logic             flag_q;
        logic [MSG_W-1:0] msg_q;

        // Pending flag: set on accept, cleared by take, accept wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (accept[k]) begin
                flag_q <= 1'b1;
            end else if (take[k]) begin
                flag_q <= 1'b0;
            end
        end

        // Payload latch: capture the message that raised this kind.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                msg_q <= '0;
            end else if (accept[k]) begin
                msg_q <= msg_data;
            end
        end

        assign pend[k]                  = flag_q;
        assign msgs[k*MSG_W +: MSG_W]   = msg_q;
    end
endmodule

// File: rtl/irq_vec_tracker.sv
// Interrupt vector request tracker: request and in-service vector sets,
// registered top vectors, special-kind flags and a word read port.
// Assumes one message, one acknowledge and one end-of-interrupt at most
// per cycle. The end-of-interrupt targets the registered top_isr.
module irq_vec_tracker #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32,
    parameter int MSG_W  = 32,
    localparam int NUM_VEC   = 1 << VEC_W,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int WSEL_W    = $clog2(NUM_WORDS),
    localparam int NSP       = irq_vec_pkg::NUM_SPECIAL
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    input  logic [2:0]           msg_kind,
    input  logic [VEC_W-1:0]     msg_vector,
    input  logic [MSG_W-1:0]     msg_data,
    input  logic                 ack_valid,
    input  logic [VEC_W-1:0]     ack_vector,
    input  logic                 eoi_valid,
    input  logic [NSP-1:0]       take,
    input  logic                 rd_sel,
    input  logic [WSEL_W-1:0]    rd_word,
    output logic [WORD_W-1:0]    rd_data,
    output logic [VEC_W-1:0]     top_req,
    output logic [VEC_W-1:0]     top_isr,
    output logic [NSP-1:0]       pend,
    output logic                 unmask_pend,
    output logic [NSP*MSG_W-1:0] spec_msgs,
    output logic [31:0]          fmt_word
);
    import irq_vec_pkg::*;

    logic [NUM_VEC-1:0] req_bits;
    logic [NUM_VEC-1:0] isr_bits;
    logic [VEC_W-1:0]   req_top_c;
    logic [VEC_W-1:0]   isr_top_c;
    logic               req_any;
    logic               isr_any;
    logic               fixed_acc;
    logic               eoi_fire;
    logic [NSP-1:0]     sp_accept;

    // A fixed-kind message is the only one that enters the request set.
    assign fixed_acc = msg_valid && (msg_kind == KIND_FIXED);

    // End-of-interrupt acts only when something is in service.
    assign eoi_fire = eoi_valid && isr_any;

    // Decode the special kinds into per-slot accept strobes.
    for (genvar k = 0; k < NSP; k++) begin : g_acc
        assign sp_accept[k] = msg_valid && (msg_kind == special_code(k));
    end

    irq_vec_set #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_req_set (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (fixed_acc),
        .set_vec (msg_vector),
        .clr_en  (ack_valid),
        .clr_vec (ack_vector),
        .bits    (req_bits)
    );

    irq_vec_set #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_isr_set (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ack_valid),
        .set_vec (ack_vector),
        .clr_en  (eoi_fire),
        .clr_vec (top_isr),
        .bits    (isr_bits)
    );

    irq_msb_find #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_req_find (
        .bits    (req_bits),
        .top     (req_top_c),
        .any_set (req_any)
    );

    irq_msb_find #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_isr_find (
        .bits    (isr_bits),
        .top     (isr_top_c),
        .any_set (isr_any)
    );

    irq_special_flags #(.MSG_W(MSG_W), .NSP(NSP)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (sp_accept),
        .msg_data (msg_data),
        .take     (take),
        .pend     (pend),
        .msgs     (spec_msgs)
    );

    // Registered top vectors, refreshed from the current set contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_req <= '0;
            top_isr <= '0;
        end else begin
            top_req <= req_any ? req_top_c : '0;
            top_isr <= isr_any ? isr_top_c : '0;
        end
    end

    // Destination format word: flat model after reset, no write path here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_word <= '1;
        end else begin
            fmt_word <= fmt_word;
        end
    end

    // Summary of the unmaskable kinds; the external kind is left out.
    assign unmask_pend = pend[SP_SMI] | pend[SP_NMI] | pend[SP_INIT];

    // Word read port over either set.
    always_comb begin
        if (rd_sel) rd_data = isr_bits[rd_word*WORD_W +: WORD_W];
        else        rd_data = req_bits[rd_word*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/irq_vec_tracker_chk.sv
// Assertion checker for irq_vec_tracker, attached with bind.
// Observes ports and the two set vectors; drives nothing into the design.
module irq_vec_tracker_chk #(
    parameter int VEC_W = 8,
    localparam int NUM_VEC = 1 << VEC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic [2:0]         msg_kind,
    input logic [VEC_W-1:0]   msg_vector,
    input logic               ack_valid,
    input logic [VEC_W-1:0]   ack_vector,
    input logic               eoi_valid,
    input logic [3:0]         take,
    input logic [VEC_W-1:0]   top_req,
    input logic [VEC_W-1:0]   top_isr,
    input logic [3:0]         pend,
    input logic               unmask_pend,
    input logic [NUM_VEC-1:0] req_bits,
    input logic [NUM_VEC-1:0] isr_bits
);
    logic [NUM_VEC-1:0] prev_req;
    logic [NUM_VEC-1:0] prev_isr;
    logic               past_ok;

    // Previous-cycle copies of both sets for the top-vector checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_req <= '0;
            prev_isr <= '0;
            past_ok  <= 1'b0;
        end else begin
            prev_req <= req_bits;
            prev_isr <= isr_bits;
            past_ok  <= 1'b1;
        end
    end

    AST_FIXED_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 3'd0) |=> req_bits[$past(msg_vector)]); // R2

    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !(msg_valid && msg_kind == 3'd0 && msg_vector == ack_vector))
        |=> (!req_bits[$past(ack_vector)] && isr_bits[$past(ack_vector)])); // R5

    AST_TOP_REQ_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_req != '0) |-> ((prev_req >> top_req) == NUM_VEC'(1))); // R3

    AST_TOP_ISR_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_isr != '0) |-> ((prev_isr >> top_isr) == NUM_VEC'(1))); // R3

    AST_TOP_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_req == '0) |-> (top_req == '0)); // R4

    AST_TOP_ISR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && prev_isr == '0) |-> (top_isr == '0)); // R4

    AST_SPECIAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind != 3'd0 && !ack_valid) |=> $stable(req_bits)); // R8

    AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && isr_bits == '0 && !ack_valid) |=> (isr_bits == '0)); // R7

    AST_EXT_NOT_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 4'b0100) |-> !unmask_pend); // R10

    for (genvar k = 0; k < 4; k++) begin : g_take
        AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (take[k] && !(msg_valid && msg_kind == 3'(k + 1))) |=> !pend[k]); // R9
    end
endmodule

bind irq_vec_tracker irq_vec_tracker_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_kind    (msg_kind),
    .msg_vector  (msg_vector),
    .ack_valid   (ack_valid),
    .ack_vector  (ack_vector),
    .eoi_valid   (eoi_valid),
    .take        (take),
    .top_req     (top_req),
    .top_isr     (top_isr),
    .pend        (pend),
    .unmask_pend (unmask_pend),
    .req_bits    (req_bits),
    .isr_bits    (isr_bits)
);

// File: tb/irq_vec_tracker_test.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them against the live outputs.
module irq_vec_tracker_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         msg_valid;
    logic [2:0]   msg_kind;
    logic [7:0]   msg_vector;
    logic [31:0]  msg_data;
    logic         ack_valid;
    logic [7:0]   ack_vector;
    logic         eoi_valid;
    logic [3:0]   take;
    logic         rd_sel;
    logic [2:0]   rd_word;
    logic [31:0]  rd_data;
    logic [7:0]   top_req;
    logic [7:0]   top_isr;
    logic [3:0]   pend;
    logic         unmask_pend;
    logic [127:0] spec_msgs;
    logic [31:0]  fmt_word;

    irq_vec_tracker uut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_vector(msg_vector), .msg_data(msg_data), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .eoi_valid(eoi_valid), .take(take),
        .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data),
        .top_req(top_req), .top_isr(top_isr), .pend(pend),
        .unmask_pend(unmask_pend), .spec_msgs(spec_msgs), .fmt_word(fmt_word)
    );

    always #5 clk = ~clk;

    typedef struct {
        string       tag;
        int          field;
        logic [31:0] exp;
    } sb_item_t;

    sb_item_t    sb[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    // Bench-side model of the requirements.
    logic [255:0] m_req = '0;
    logic [255:0] m_isr = '0;
    logic [3:0]   m_pend = '0;
    logic [31:0]  m_msg [4];

    function automatic logic [7:0] mtop(input logic [255:0] s);
        logic [7:0] t = '0;
        for (int i = 0; i < 256; i++) if (s[i]) t = 8'(i);
        return t;
    endfunction

    function automatic logic [31:0] actual(input int field);
        case (field)
            0: return {24'd0, top_req};
            1: return {24'd0, top_isr};
            2: return {28'd0, pend};
            3: return {31'd0, unmask_pend};
            4: return rd_data;
            5: return fmt_word;
            default: return spec_msgs[(field-6)*32 +: 32];
        endcase
    endfunction

    task automatic push(input string tag, input int field, input logic [31:0] exp);
        sb_item_t it;
        it.tag = tag; it.field = field; it.exp = exp;
        sb.push_back(it);
        #1;
    endtask

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            sb_item_t it;
            logic [31:0] act;
            wait (sb.size() != 0);
            it  = sb.pop_front();
            act = actual(it.field);
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s field %0d: actual %h expected %h", it.tag, it.field, act, it.exp);
            end
        end
    end

    task automatic expect_state(input string tag);
        push(tag, 0, {24'd0, mtop(m_req)});
        push(tag, 1, {24'd0, mtop(m_isr)});
        push(tag, 2, {28'd0, m_pend});
        push(tag, 3, {31'd0, m_pend[0] | m_pend[1] | m_pend[3]});
    endtask

    task automatic expect_word(input string tag, input logic sel, input logic [2:0] w);
        rd_sel = sel; rd_word = w;
        #1;
        push(tag, 4, sel ? m_isr[w*32 +: 32] : m_req[w*32 +: 32]);
    endtask

    // One-cycle operation, model update, then settle to the top outputs.
    task automatic drive(input logic mv, input logic [2:0] mk, input logic [7:0] mvec,
                         input logic [31:0] md, input logic av, input logic [7:0] avec,
                         input logic eo, input logic [3:0] tk, input bit lat_chk);
        logic [7:0] old_req_top = mtop(m_req);
        logic [7:0] old_isr_top = mtop(m_isr);
        @(negedge clk);
        msg_valid = mv; msg_kind = mk; msg_vector = mvec; msg_data = md;
        ack_valid = av; ack_vector = avec; eoi_valid = eo; take = tk;
        if (eo && m_isr != '0) m_isr[old_isr_top] = 1'b0;
        if (av) begin m_req[avec] = 1'b0; m_isr[avec] = 1'b1; end
        if (mv && mk == 3'd0) m_req[mvec] = 1'b1;
        m_pend = m_pend & ~tk;
        if (mv && mk >= 3'd1 && mk <= 3'd4) begin
            m_pend[mk - 3'd1] = 1'b1;
            m_msg[mk - 3'd1]  = md;
        end
        @(negedge clk);
        msg_valid = 0; ack_valid = 0; eoi_valid = 0; take = '0;
        if (lat_chk) begin
            push("R12 top_req lags one cycle", 0, {24'd0, old_req_top});
            push("R12 top_isr lags one cycle", 1, {24'd0, old_isr_top});
        end
        @(negedge clk);
    endtask

    // Watchdog: counts as a failure and still reports the summary.
    initial begin
        #2000000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (m_msg[i]) m_msg[i] = '0;
        rst_n = 0; msg_valid = 0; msg_kind = 0; msg_vector = 0; msg_data = 0;
        ack_valid = 0; ack_vector = 0; eoi_valid = 0; take = 0; rd_sel = 0; rd_word = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        expect_state("R1 reset");
        push("R1 fmt_word", 5, 32'hFFFF_FFFF);
        expect_word("R1 req word7", 1'b0, 3'd7);
        expect_word("R1 isr word0", 1'b1, 3'd0);

        // R2: vector 0x47 lands in word 2 bit 7
        drive(1, 3'd0, 8'h47, 0, 0, 0, 0, 4'd0, 0);
        push("R2 req word2 bit7", 4, 32'h0);
        rd_sel = 0; rd_word = 3'd2; #1;
        push("R2 req word2 bit7", 4, 32'h0000_0080);
        expect_state("R2 state");

        // R12: latency of the top output, vector 200
        drive(1, 3'd0, 8'd200, 0, 0, 0, 0, 4'd0, 1);
        expect_state("R12 settled");

        // R3: vectors 5 and 255, highest wins
        drive(1, 3'd0, 8'd5, 0, 0, 0, 0, 4'd0, 0);
        drive(1, 3'd0, 8'd255, 0, 0, 0, 0, 4'd0, 0);
        push("R3 top_req 255", 0, 32'd255);
        expect_word("R3 req word7", 1'b0, 3'd7);
        expect_word("R3 req word6", 1'b0, 3'd6);
        expect_word("R3 req word0", 1'b0, 3'd0);

        // R5: acknowledge moves 255 and 5
        drive(0, 0, 0, 0, 1, 8'd255, 0, 4'd0, 0);
        push("R5 top_req 200", 0, 32'd200);
        push("R5 top_isr 255", 1, 32'd255);
        expect_word("R5 isr word7", 1'b1, 3'd7);
        expect_word("R5 req word7", 1'b0, 3'd7);
        drive(0, 0, 0, 0, 1, 8'd5, 0, 4'd0, 0);
        expect_state("R5 second ack");

        // R7: end-of-interrupt drains top down, then no effect when empty
        drive(0, 0, 0, 0, 0, 0, 1, 4'd0, 0);
        push("R7 top_isr 5", 1, 32'd5);
        drive(0, 0, 0, 0, 0, 0, 1, 4'd0, 0);
        expect_state("R7 drained");
        drive(0, 0, 0, 0, 0, 0, 1, 4'd0, 0);
        expect_state("R7 empty eoi");
        expect_word("R7 isr word0 empty", 1'b1, 3'd0);
        // R4: empty in-service set reports zero
        push("R4 empty top_isr", 1, 32'd0);

        // R6: request and acknowledge of 0x47 in one cycle
        drive(1, 3'd0, 8'h47, 0, 1, 8'h47, 0, 4'd0, 0);
        expect_word("R6 req kept", 1'b0, 3'd2);
        expect_word("R6 isr set", 1'b1, 3'd2);
        expect_state("R6 state");

        // R8: special kinds raise flags, latch payloads, skip the request set
        drive(1, 3'd1, 8'd10, 32'hA5A5_0001, 0, 0, 0, 4'd0, 0);
        drive(1, 3'd2, 8'd11, 32'h5A5A_0002, 0, 0, 0, 4'd0, 0);
        drive(1, 3'd3, 8'd12, 32'hC3C3_0003, 0, 0, 0, 4'd0, 0);
        drive(1, 3'd4, 8'd13, 32'h3C3C_0004, 0, 0, 0, 4'd0, 0);
        expect_state("R8 flags");
        for (int k = 0; k < 4; k++) push("R8 payload", 6 + k, m_msg[k]);
        expect_word("R8 req word0 untouched", 1'b0, 3'd0);

        // R9: take clears, accept beats take of the same kind
        drive(0, 0, 0, 0, 0, 0, 0, 4'b0010, 0);
        expect_state("R9 take nmi");
        drive(1, 3'd1, 0, 32'h1111_2222, 0, 0, 0, 4'b0001, 0);
        expect_state("R9 accept wins");
        push("R9 smi payload", 6, 32'h1111_2222);

        // R10: external alone leaves the summary low
        drive(0, 0, 0, 0, 0, 0, 0, 4'b1001, 0);
        push("R10 ext only unmask", 3, 32'd0);
        expect_state("R10 state");

        // R11: unused kind codes do nothing
        for (int c = 5; c < 8; c++) drive(1, 3'(c), 8'd9, 32'hDEAD_BEEF, 0, 0, 0, 4'd0, 0);
        expect_state("R11 ignored");
        expect_word("R11 req word0", 1'b0, 3'd0);
        push("R11 ext payload kept", 8, 32'hC3C3_0003);

        wait (sb.size() == 0);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule